// File: doc/BRIEF.md
# DS1 Signaling Phase Sync Monitor

This block watches one DS1 channel that is carried byte-synchronously inside a virtual tributary. On each frame strobe it receives a two-bit phase indicator, the F bit and the four signaling bits. It keeps its own frame position inside a 24-frame multiframe, and it marks a multiframe as bad when any phase indicator in it does not match that position. A sync state machine qualifies these multiframes. Two good multiframes in a row are needed to enter sync. A programmable run of bad multiframes is needed to leave it.

The sync state selects what happens to the outgoing F bit. It can pass unchanged, or it can be rewritten with the 12-frame superframe pattern or the 24-frame extended superframe pattern. When sync is lost, the block can instead request DS1 AIS and force the signaling bits to a programmed default. Every change of the loss-of-sync status sets a sticky change flag. A mask decides whether that flag raises the interrupt output. Channel routing and register access are handled outside the block.

The state machine has four states:

- OFF: phase sync is disabled and loss is reported as 0.
- LOST: out of sync, with no good multiframe counted yet.
- GOOD1: out of sync, with one good multiframe counted.
- SYNC: in sync.

Its transitions are:

- OFF to LOST when the enable is set.
- LOST to GOOD1 on a good multiframe.
- GOOD1 to SYNC on a good multiframe.
- GOOD1 to LOST on a bad multiframe.
- SYNC to LOST when the count of consecutive bad multiframes reaches the threshold.
- Any state to OFF when the enable is cleared.

Top module: `ds1_phase_monitor`

## Requirements
- R1: Frame positions run from 0 to 23. A frame strobe with `mf_start` high has position 0. Every other frame strobe has the previous position plus one, wrapping from 23 to 0. The expected phase indicator of a frame is its position mod 4. A multiframe is bad if any of its frames carries an indicator that differs from the expected value. A `mf_start` strobe discards the errors of any partial multiframe.
- R2: From LOST, two consecutive good multiframes bring `lops` to 0. The change appears one clock after the frame strobe of the 24th frame (position 23) of the second good multiframe.
- R3: In SYNC, `lops` becomes 1 once the number of consecutive bad multiframes reaches `lops_ntime`. A threshold of 0 acts as 1. A good multiframe resets the bad count.
- R4: A bad multiframe after exactly one good multiframe restarts qualification, so two further good multiframes are then needed.
- R5: Any change of `lops` sets `lops_delta`. A high `delta_clr` clears it. A change in the same cycle as a clear leaves the flag set.
- R6: `irq` is high exactly when `lops_delta` and `irq_mask` are both 1.
- R7: When `sync_en`=1, `lops`=1 and `ais_inh`=0, the outputs are `ais_req`=1, `f_out`=1 and `sig_out`=`sig_dflt`. In every other case `ais_req`=0 and `sig_out`=`sig_in`.
- R8: With `sync_en`=1 and `lops`=0, `f_out` is regenerated.
  - SF mode (`esf_mode`=0): position mod 12 selects bits 1,0,0,0,1,1,0,1,1,1,0,0, in order from remainder 0.
  - ESF mode (`esf_mode`=1): positions 3,7,11,15,19,23 carry 0,0,1,0,1,1. All other positions pass `f_in`.
- R9: With `sync_en`=0, `lops` is held at 0 from one clock after the enable clears. With `fbit_wr_en`=1 the F bit is regenerated as in R8. With `fbit_wr_en`=0 `f_out` equals `f_in`.
- R10: After reset, `lops`=1, `lops_delta`=0 and `irq`=0.
- R11: When `sync_en`=1, `lops`=1 and `ais_inh`=1, `f_out` equals `f_in` and no AIS is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe per received frame |
| mf_start | input | 1 | With `frame_stb`, marks the first frame of a multiframe |
| phase_in | input | 2 | Received phase indicator |
| f_in | input | 1 | Received F bit |
| sig_in | input | 4 | Received signaling bits |
| sync_en | input | 1 | Enable phase-indicator synchronization |
| fbit_wr_en | input | 1 | Regenerate the F bit while sync is disabled |
| esf_mode | input | 1 | 1 selects the ESF pattern, 0 selects the SF pattern |
| ais_inh | input | 1 | Suppress AIS on loss of sync |
| lops_ntime | input | 4 | Number of bad multiframes that declares loss |
| sig_dflt | input | 4 | Forced signaling value during AIS |
| delta_clr | input | 1 | Clear strobe for the change flag |
| irq_mask | input | 1 | 1 lets the change flag drive `irq` |
| f_out | output | 1 | Outgoing F bit |
| sig_out | output | 4 | Outgoing signaling bits |
| ais_req | output | 1 | Request DS1 AIS downstream |
| lops | output | 1 | Loss of phase synchronization |
| lops_delta | output | 1 | Sticky change flag of `lops` |
| irq | output | 1 | Interrupt |

## Verification
Two events can fall in the same cycle: a status change and a clear of the change flag. This happens when `delta_clr` arrives on the frame strobe that completes a qualifying multiframe. The bench provokes the case directly by asserting the clear on the 24th frame of the second good multiframe. It also lets random clears land on random multiframe ends. In each case the flag must read 1 one cycle later, so the change wins over the clear. A second overlap arises between the AIS decision and F-bit regeneration. The bench checks every frame against a reference model that selects exactly one of AIS, regeneration or pass-through.

// File: rtl/ds1pm_pkg.sv
package ds1pm_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_LOST  = 2'd1,
        ST_GOOD1 = 2'd2,
        ST_SYNC  = 2'd3
    } sync_st_t;

    typedef enum logic [1:0] {
        FM_PASS  = 2'd0,
        FM_REGEN = 2'd1,
        FM_AIS   = 2'd2
    } fmode_t;

    // 12-frame superframe framing bit for a frame position
    function automatic logic sf_fbit(input int unsigned pos);
        logic [11:0] pat;
        logic [11:0] sh;
        pat = 12'b1000_1101_1100;
        sh  = pat >> (11 - (pos % 12));
        return sh[0];
    endfunction

    // Framing positions of the 24-frame extended superframe
    function automatic logic esf_is_fps(input int unsigned pos);
        return (pos % 4) == 3;
    endfunction

    function automatic logic esf_fbit(input int unsigned pos);
        logic [5:0] pat;
        logic [5:0] sh;
        pat = 6'b001011;
        sh  = pat >> (5 - ((pos / 4) % 6));
        return sh[0];
    endfunction

endpackage

// File: rtl/ds1pm_mf_qual.sv
module ds1pm_mf_qual #(
    parameter int FRAMES_PER_MF = 24,
    parameter int PH_W          = 2,
    localparam int IDX_W        = $clog2(FRAMES_PER_MF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             mf_start,
    input  logic [PH_W-1:0]  phase_in,
    output logic [IDX_W-1:0] cur_idx,
    output logic             mf_done,
    output logic             mf_bad
);
    logic [IDX_W-1:0] cnt_q;
    logic             acc_q;
    logic             last;
    logic             miss;
    logic             acc_base;

    always_comb begin
        cur_idx  = mf_start ? '0 : cnt_q;
        last     = (cur_idx == IDX_W'(FRAMES_PER_MF - 1));
        miss     = (phase_in != cur_idx[PH_W-1:0]);
        acc_base = mf_start ? 1'b0 : acc_q;
        mf_done  = frame_stb & last;
        mf_bad   = acc_base | miss;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= 1'b0;
        end else if (frame_stb) begin
            cnt_q <= last ? '0 : cur_idx + IDX_W'(1);
            acc_q <= last ? 1'b0 : (acc_base | miss);
        end
    end
endmodule

// File: rtl/ds1pm_sync_fsm.sv
module ds1pm_sync_fsm
    import ds1pm_pkg::*;
#(
    parameter int NT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_en,
    input  logic            mf_done,
    input  logic            mf_bad,
    input  logic [NT_W-1:0] ntime,
    output logic            lops,
    output logic            lops_chg
);
    sync_st_t        state_q, state_d;
    logic [NT_W-1:0] bad_cnt_q;
    logic [NT_W-1:0] n_eff;
    logic [NT_W:0]   bad_nxt;

    assign n_eff   = (ntime == '0) ? NT_W'(1) : ntime;
    assign bad_nxt = {1'b0, bad_cnt_q} + (NT_W+1)'(1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (sync_en) state_d = ST_LOST;
            ST_LOST: begin
                if (!sync_en)                state_d = ST_OFF;
                else if (mf_done && !mf_bad) state_d = ST_GOOD1;
            end
            ST_GOOD1: begin
                if (!sync_en)     state_d = ST_OFF;
                else if (mf_done) state_d = mf_bad ? ST_LOST : ST_SYNC;
            end
            ST_SYNC: begin
                if (!sync_en)
                    state_d = ST_OFF;
                else if (mf_done && mf_bad && (bad_nxt >= {1'b0, n_eff}))
                    state_d = ST_LOST;
            end
            default:  state_d = ST_LOST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_LOST;
            bad_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_SYNC || state_d != ST_SYNC)
                bad_cnt_q <= '0;
            else if (mf_done)
                bad_cnt_q <= mf_bad ? bad_nxt[NT_W-1:0] : '0;
        end
    end

    always_comb begin
        lops     = (state_q == ST_LOST) || (state_q == ST_GOOD1);
        lops_chg = lops != ((state_d == ST_LOST) || (state_d == ST_GOOD1));
    end
endmodule

// File: rtl/ds1pm_delta.sv
module ds1pm_delta (
    input  logic clk,
    input  logic rst_n,
    input  logic chg,
    input  logic clr,
    input  logic mask,
    output logic delta,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)   delta <= 1'b0;
        else if (chg) delta <= 1'b1;
        else if (clr) delta <= 1'b0;
    end

    assign irq = delta & mask;
endmodule

// File: rtl/ds1pm_fbit_sel.sv
module ds1pm_fbit_sel
    import ds1pm_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int SIG_W = 4
) (
    input  logic             sync_en,
    input  logic             fbit_wr_en,
    input  logic             esf_mode,
    input  logic             ais_inh,
    input  logic             lops,
    input  logic [IDX_W-1:0] idx,
    input  logic             f_in,
    input  logic [SIG_W-1:0] sig_in,
    input  logic [SIG_W-1:0] sig_dflt,
    output logic             f_out,
    output logic [SIG_W-1:0] sig_out,
    output logic             ais_req
);
    fmode_t      mode;
    logic        regen;
    int unsigned pos;

    always_comb begin
        pos = 32'(idx);
        if (sync_en && lops && !ais_inh)
            mode = FM_AIS;
        else if ((sync_en && !lops) || (!sync_en && fbit_wr_en))
            mode = FM_REGEN;
        else
            mode = FM_PASS;

        if (esf_mode)
            regen = esf_is_fps(pos) ? esf_fbit(pos) : f_in;
        else
            regen = sf_fbit(pos);

        unique case (mode)
            FM_AIS: begin
                f_out   = 1'b1;
                sig_out = sig_dflt;
                ais_req = 1'b1;
            end
            FM_REGEN: begin
                f_out   = regen;
                sig_out = sig_in;
                ais_req = 1'b0;
            end
            default: begin
                f_out   = f_in;
                sig_out = sig_in;
                ais_req = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ds1_phase_monitor.sv
module ds1_phase_monitor #(
    parameter int FRAMES_PER_MF = 24,
    parameter int PH_W          = 2,
    parameter int NT_W          = 4,
    parameter int SIG_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_stb,
    input  logic             mf_start,
    input  logic [PH_W-1:0]  phase_in,
    input  logic             f_in,
    input  logic [SIG_W-1:0] sig_in,
    input  logic             sync_en,
    input  logic             fbit_wr_en,
    input  logic             esf_mode,
    input  logic             ais_inh,
    input  logic [NT_W-1:0]  lops_ntime,
    input  logic [SIG_W-1:0] sig_dflt,
    input  logic             delta_clr,
    input  logic             irq_mask,
    output logic             f_out,
    output logic [SIG_W-1:0] sig_out,
    output logic             ais_req,
    output logic             lops,
    output logic             lops_delta,
    output logic             irq
);
    localparam int IDX_W = $clog2(FRAMES_PER_MF);

    logic [IDX_W-1:0] cur_idx;
    logic             mf_done;
    logic             mf_bad;
    logic             lops_chg;

    ds1pm_mf_qual #(.FRAMES_PER_MF(FRAMES_PER_MF), .PH_W(PH_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mf_start(mf_start),
        .phase_in(phase_in), .cur_idx(cur_idx), .mf_done(mf_done), .mf_bad(mf_bad)
    );

    ds1pm_sync_fsm #(.NT_W(NT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .mf_done(mf_done),
        .mf_bad(mf_bad), .ntime(lops_ntime), .lops(lops), .lops_chg(lops_chg)
    );

    ds1pm_delta u_delta (
        .clk(clk), .rst_n(rst_n), .chg(lops_chg), .clr(delta_clr),
        .mask(irq_mask), .delta(lops_delta), .irq(irq)
    );

    ds1pm_fbit_sel #(.IDX_W(IDX_W), .SIG_W(SIG_W)) u_fsel (
        .sync_en(sync_en), .fbit_wr_en(fbit_wr_en), .esf_mode(esf_mode),
        .ais_inh(ais_inh), .lops(lops), .idx(cur_idx), .f_in(f_in),
        .sig_in(sig_in), .sig_dflt(sig_dflt), .f_out(f_out),
        .sig_out(sig_out), .ais_req(ais_req)
    );
endmodule

// File: rtl/ds1_phase_monitor_chk.sv
module ds1_phase_monitor_chk #(
    parameter int SIG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_stb,
    input logic             f_in,
    input logic             sync_en,
    input logic             fbit_wr_en,
    input logic             delta_clr,
    input logic [SIG_W-1:0] sig_dflt,
    input logic             f_out,
    input logic [SIG_W-1:0] sig_out,
    input logic             ais_req,
    input logic             lops,
    input logic             lops_delta,
    input logic             irq
);
    AST_DELTA_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lops != $past(lops)) |-> lops_delta); // R5
    AST_DELTA_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lops_delta) |-> $past(delta_clr)); // R5
    AST_IRQ_NEEDS_DELTA: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> lops_delta); // R6
    AST_AIS_FORCES_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        ais_req |-> (sig_out == sig_dflt && f_out)); // R7
    AST_SYNC_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lops) && sync_en) |-> $past(frame_stb)); // R2
    AST_NO_LOSS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en && $past(!sync_en)) |-> !lops); // R9
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_en && !fbit_wr_en) |-> (f_out == f_in)); // R9
endmodule

bind ds1_phase_monitor ds1_phase_monitor_chk #(.SIG_W(SIG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .f_in(f_in),
    .sync_en(sync_en), .fbit_wr_en(fbit_wr_en), .delta_clr(delta_clr),
    .sig_dflt(sig_dflt), .f_out(f_out), .sig_out(sig_out), .ais_req(ais_req),
    .lops(lops), .lops_delta(lops_delta), .irq(irq)
);

// File: tb/ds1_phase_monitor_test.sv
`timescale 1ns/1ps
module ds1_phase_monitor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_stb = 0, mf_start = 0, f_in = 0;
    logic [1:0] phase_in = 0;
    logic [3:0] sig_in = 0, sig_dflt = 4'hA, lops_ntime = 4'd3;
    logic       sync_en = 1, fbit_wr_en = 0, esf_mode = 0, ais_inh = 0;
    logic       delta_clr = 0, irq_mask = 1;
    logic       f_out, ais_req, lops, lops_delta, irq;
    logic [3:0] sig_out;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    int cnt_m = 0, err_m = 0, good_run = 0, bad_run = 0;
    bit lops_m = 1, delta_m = 0, off_m = 0;

    always #2.5 clk = ~clk;

    ds1_phase_monitor uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .mf_start(mf_start),
        .phase_in(phase_in), .f_in(f_in), .sig_in(sig_in), .sync_en(sync_en),
        .fbit_wr_en(fbit_wr_en), .esf_mode(esf_mode), .ais_inh(ais_inh),
        .lops_ntime(lops_ntime), .sig_dflt(sig_dflt), .delta_clr(delta_clr),
        .irq_mask(irq_mask), .f_out(f_out), .sig_out(sig_out), .ais_req(ais_req),
        .lops(lops), .lops_delta(lops_delta), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit ref_sf(input int pos);
        bit tab[12] = '{1,0,0,0,1,1,0,1,1,1,0,0};
        return tab[pos % 12];
    endfunction

    function automatic bit ref_f(input int pos, input bit fin);
        bit etab[6] = '{0,0,1,0,1,1};
        if (esf_mode) return (pos % 4 == 3) ? etab[pos / 4] : fin;
        return ref_sf(pos);
    endfunction

    task automatic check_post();
        chk("R1 lops", int'(lops), int'(lops_m));
        chk("R5 delta", int'(lops_delta), int'(delta_m));
        chk("R6 irq", int'(irq), int'(delta_m & irq_mask));
    endtask

    task automatic do_frame(input bit mf, input logic [1:0] ph, input bit fin,
                            input logic [3:0] sg, input bit clr);
        int  idx;
        bit  ais, regen, miss, bad, prev;
        bit  ef;
        int  neff;
        string rq;
        @(negedge clk);
        frame_stb = 1; mf_start = mf; phase_in = ph; f_in = fin; sig_in = sg;
        delta_clr = clr;
        idx   = mf ? 0 : cnt_m;
        ais   = sync_en && lops_m && !ais_inh;
        regen = (sync_en && !lops_m) || (!sync_en && fbit_wr_en);
        if (ais)          begin ef = 1;                rq = "R7 f_out";  end
        else if (regen)   begin ef = ref_f(idx, fin);  rq = sync_en ? "R8 f_out" : "R9 f_out"; end
        else              begin ef = fin;              rq = sync_en ? "R11 f_out" : "R9 f_out"; end
        #1;
        chk(rq, int'(f_out), int'(ef));
        chk("R7 sig_out", int'(sig_out), ais ? int'(sig_dflt) : int'(sg));
        chk("R7 ais_req", int'(ais_req), int'(ais));
        @(posedge clk);
        miss = (int'(ph) != (idx % 4));
        bad  = (mf ? 0 : err_m) | miss;
        prev = lops_m;
        if (idx == 23) begin
            err_m = 0; cnt_m = 0;
            if (sync_en && !off_m) begin
                neff = (lops_ntime == 0) ? 1 : int'(lops_ntime);
                if (bad) begin
                    good_run = 0; bad_run++;
                    if (!lops_m && bad_run >= neff) lops_m = 1;
                end else begin
                    bad_run = 0;
                    if (lops_m) begin
                        good_run++;
                        if (good_run >= 2) begin lops_m = 0; good_run = 0; end
                    end
                end
            end
        end else begin
            err_m = bad; cnt_m = idx + 1;
        end
        if (prev != lops_m) delta_m = 1; else if (clr) delta_m = 0;
        @(negedge clk);
        frame_stb = 0; mf_start = 0; delta_clr = 0;
        #1;
        check_post();
    endtask

    task automatic set_en(input bit v);
        bit prev;
        @(negedge clk);
        sync_en = v;
        prev = lops_m;
        if (!v) begin lops_m = 0; off_m = 1; end
        else if (off_m) begin lops_m = 1; off_m = 0; end
        good_run = 0; bad_run = 0;
        if (prev != lops_m) delta_m = 1;
        @(negedge clk); #1;
        check_post();
    endtask

    // one multiframe; bad_at >= 0 corrupts that frame's phase indicator
    task automatic run_mf(input int bad_at, input bit clr_last);
        for (int i = 0; i < 24; i++) begin
            logic [1:0] ph;
            ph = 2'(i % 4);
            if (i == bad_at) ph = ph ^ 2'(1 + $urandom_range(0, 2));
            do_frame(i == 0, ph, 1'($urandom), 4'($urandom),
                     clr_last && (i == 23));
        end
    endtask

    task automatic clear_delta();
        @(negedge clk); delta_clr = 1;
        @(negedge clk); delta_clr = 0; delta_m = 0; #1;
        chk("R5 clear", int'(lops_delta), 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1; #1;
        chk("R10 lops", int'(lops), 1);
        chk("R10 delta", int'(lops_delta), 0);
        chk("R10 irq", int'(irq), 0);

        // R2 with R5 priority: clear on the qualifying frame
        run_mf(-1, 0);
        chk("R2 still lost after one", int'(lops), 1);
        run_mf(-1, 1);
        chk("R2 sync", int'(lops), 0);
        chk("R5 set beats clear", int'(lops_delta), 1);
        chk("R6 irq", int'(irq), 1);
        clear_delta();

        // R8 ESF regeneration while in sync
        esf_mode = 1; run_mf(-1, 0); esf_mode = 0;

        // R3 threshold zero acts as one
        lops_ntime = 0; run_mf(10, 0);
        chk("R3 loss ntime0", int'(lops), 1);
        lops_ntime = 2;

        // R4 good, bad, good, good
        run_mf(-1, 0); run_mf(5, 0); run_mf(-1, 0);
        chk("R4 restart", int'(lops), 1);
        run_mf(-1, 0);
        chk("R4 sync", int'(lops), 0);

        // R3 good run resets bad count
        run_mf(0, 0); run_mf(-1, 0); run_mf(23, 0);
        chk("R3 no loss", int'(lops), 0);
        run_mf(3, 0);
        chk("R3 loss at 2", int'(lops), 1);

        // R11 inhibit while lost
        ais_inh = 1; run_mf(2, 0); ais_inh = 0;

        // R9 disabled: regen then pass
        set_en(0);
        fbit_wr_en = 1; run_mf(-1, 0); esf_mode = 1; run_mf(4, 0);
        fbit_wr_en = 0; esf_mode = 0; run_mf(-1, 0);
        chk("R9 lops held", int'(lops), 0);
        set_en(1);

        // random phase
        for (int m = 0; m < 150; m++) begin
            int bad_at;
            lops_ntime = 4'($urandom_range(0, 4));
            esf_mode   = 1'($urandom);
            fbit_wr_en = 1'($urandom);
            ais_inh    = ($urandom_range(0, 3) == 0);
            irq_mask   = 1'($urandom);
            sig_dflt   = 4'($urandom);
            if ($urandom_range(0, 19) == 0) set_en(!sync_en);
            bad_at = ($urandom_range(0, 9) < 3) ? $urandom_range(0, 23) : -1;
            for (int i = 0; i < 24; i++) begin
                logic [1:0] ph;
                ph = 2'(i % 4);
                if (i == bad_at) ph = ~ph;
                do_frame(i == 0, ph, 1'($urandom), 4'($urandom),
                         $urandom_range(0, 9) == 0);
            end
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule